// File: doc/BRIEF.md
# Prefixed 8-bit Opcode Decoder

This block classifies the opcode stream of a small 8-bit accumulator machine. Opcode bytes arrive one per cycle over a valid/ready handshake. For each complete instruction the block produces one registered result. The result holds an operation code, an addressing-mode group, a stack-relative flag, an invalid flag and the number of opcode bytes the instruction took. It does not fetch operands, execute, update flags or model memory timing.

Most opcodes are one byte. The upper nibble picks a row and the lower nibble picks a slot, and a number of individual codes override their slot. One byte value works as an escape prefix. It produces no result of its own; it sends the next byte through a second, stack-relative map. After reset the block first spends one cycle asking for the start address, which is the 16-bit word stored high byte first at a fixed vector address. No opcode is accepted in that cycle.

Top module: `opdec_top`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `vec_load` is 1, `in_ready` is 0 and `vec_addr` is 0xFFFE. An offered byte is ignored in that cycle. From then on `vec_load` stays 0.
- R2: Outside the vector cycle `in_ready` is 1. A byte is taken at a clock edge when `in_valid` and `in_ready` are both 1. `res_valid` is 1 for exactly the one cycle after the edge that took the final byte of an instruction, and is 0 at all other times.
- R3: The byte 0x9E taken with no prefix pending gives no result and leaves a prefix pending. The next byte taken is decoded through the escape map, and that clears the pending prefix.
- R4: `res_grp` follows the upper nibble of the decoded byte for valid codes: 0→1 (bit test-and-branch, OP_BRBIT), 1→2 (bit set/clear, OP_BSETCLR), 2→3 (branch, OP_BRCOND), 3..7→4 (read-modify-write), 8→5 (control), 9→6 (branch/transfer/flag), A..F→7 (ALU). Any invalid result has group 0.
- R5: In rows 3..7 the low nibbles 0,1,3,4,6,7,8,9,A,B,C,D,F give NEG, CBEQ, COM, LSR, ROR, ASR, LSL, ROL, DEC, DBNZ, INC, TST, CLR. The operation is reported as the package enumeration value OP_<mnemonic>. OP_INV is value 0.
- R6: Slot exceptions in rows 3..7: 0x32 LDHX, 0x42 MUL, 0x52 DIV, 0x62 NSA, 0x72 DAA; 0x35 STHX, 0x45 and 0x55 LDHX, 0x65 and 0x75 CPHX; 0x3E CPHX and 0x4E..0x7E MOV.
- R7: Rows A..F map low nibbles 0..F to SUB, CMP, SBC, CPX, AND, BIT, LDA, STA, EOR, ADC, ORA, ADD, JMP, JSR, LDX, STX. In row A, 0xA7 is AIS, 0xAD is BSR and 0xAF is AIX.
- R8: Row 8: 0x80 RTI, 0x81 RTS, 0x83 SWI, 0x84/0x85 XFER, 0x86..0x8B PSHPUL, 0x8C CLRH, 0x8E STOP, 0x8F WAIT. Row 9: 0x90..0x93 BRCOND, 0x94/0x95/0x97/0x9F XFER, 0x96 STHX, 0x98..0x9B FLAGOP, 0x9C RSP, 0x9D NOP.
- R9: After the prefix, 0x6x gives the row 3..7 slot operation in group 4. 0xDx and 0xEx give the ALU slot operation in group 7. 0xAE/0xBE/0xCE/0xFE give LDHX, 0xF3 gives CPHX and 0xFF gives STHX, all in group 7. Each of these valid results has `res_stack` = 1.
- R10: After the prefix, 0x62, 0x65, 0x6E, 0xDC, 0xDD, 0xEC, 0xED and every second byte not listed in R9 (0x9E included) give `res_inv` = 1, OP_INV, group 0 and `res_stack` = 0.
- R11: Without the prefix, only 0x82, 0x8D and 0xAC are invalid. `res_stack` is 0 for every one-byte result.
- R12: Reset asserted while a prefix is pending clears it, so the first byte after the vector cycle is decoded through the one-byte map.
- R13: `res_bytes` is 2 for every result reached through the prefix and 1 for all other results. Each byte taken counts one fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Opcode byte offered |
| in_byte | input | 8 | Opcode byte |
| in_ready | output | 1 | Byte can be taken this cycle |
| vec_load | output | 1 | Start-address load cycle |
| vec_addr | output | 16 | Address of the start-address word |
| res_valid | output | 1 | Result present this cycle |
| res_op | output | 6 | Operation code (package enumeration) |
| res_grp | output | 3 | Addressing-mode group |
| res_stack | output | 1 | Stack-relative instruction |
| res_inv | output | 1 | Invalid instruction |
| res_bytes | output | 2 | Opcode bytes fetched for this instruction |

## Verification
The one-byte map is swept over all 256 values except the prefix, with idle gaps scattered between bytes. This separates the row rules from the per-code overrides and shows that gaps do not disturb results. The escape map is then swept by pairing the prefix with every second byte, sometimes with a gap between prefix and byte, which tests that the pending state survives idle cycles. Directed sequences cover a doubled prefix, prefixed and plain instructions run back to back, a byte offered during the vector cycle, and a reset that arrives between the prefix and its second byte.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int OP_W   = 6;
    localparam int GRP_W  = 3;
    localparam int CNT_W  = 2;

    typedef enum logic [OP_W-1:0] {
        OP_INV = 6'd0,
        OP_NEG, OP_CBEQ, OP_COM, OP_LSR, OP_ROR, OP_ASR, OP_LSL, OP_ROL,
        OP_DEC, OP_DBNZ, OP_INC, OP_TST, OP_CLR,
        OP_LDHX, OP_MUL, OP_DIV, OP_NSA, OP_DAA, OP_STHX, OP_CPHX, OP_MOV,
        OP_SUB, OP_CMP, OP_SBC, OP_CPX, OP_AND, OP_BIT, OP_LDA, OP_STA,
        OP_EOR, OP_ADC, OP_ORA, OP_ADD, OP_JMP, OP_JSR, OP_LDX, OP_STX,
        OP_AIS, OP_BSR, OP_AIX,
        OP_RTI, OP_RTS, OP_SWI, OP_XFER, OP_PSHPUL, OP_CLRH, OP_STOP, OP_WAIT,
        OP_BRCOND, OP_FLAGOP, OP_RSP, OP_NOP, OP_BRBIT, OP_BSETCLR
    } op_e;

    typedef enum logic [GRP_W-1:0] {
        GRP_NONE   = 3'd0,
        GRP_BITBR  = 3'd1,
        GRP_BITSC  = 3'd2,
        GRP_BRANCH = 3'd3,
        GRP_RMW    = 3'd4,
        GRP_CTRL   = 3'd5,
        GRP_MISC   = 3'd6,
        GRP_ALU    = 3'd7
    } grp_e;

    typedef struct packed {
        op_e  op;
        grp_e grp;
        logic inv;
    } dec_t;

    typedef struct packed {
        logic             vec;
        logic             pend;
        logic             rvalid;
        logic             stack;
        logic [CNT_W-1:0] nbytes;
        dec_t             dec;
    } seq_t;

    // Slot meaning in the read-modify-write rows (shared by both maps)
    function automatic op_e rmw_slot(input logic [NIB_W-1:0] lo);
        op_e r;
        case (lo)
            4'h0: r = OP_NEG;
            4'h1: r = OP_CBEQ;
            4'h3: r = OP_COM;
            4'h4: r = OP_LSR;
            4'h6: r = OP_ROR;
            4'h7: r = OP_ASR;
            4'h8: r = OP_LSL;
            4'h9: r = OP_ROL;
            4'hA: r = OP_DEC;
            4'hB: r = OP_DBNZ;
            4'hC: r = OP_INC;
            4'hD: r = OP_TST;
            4'hF: r = OP_CLR;
            default: r = OP_INV;
        endcase
        return r;
    endfunction

    // Slot meaning in the accumulator/index rows (shared by both maps)
    function automatic op_e alu_slot(input logic [NIB_W-1:0] lo);
        op_e r;
        case (lo)
            4'h0: r = OP_SUB;
            4'h1: r = OP_CMP;
            4'h2: r = OP_SBC;
            4'h3: r = OP_CPX;
            4'h4: r = OP_AND;
            4'h5: r = OP_BIT;
            4'h6: r = OP_LDA;
            4'h7: r = OP_STA;
            4'h8: r = OP_EOR;
            4'h9: r = OP_ADC;
            4'hA: r = OP_ORA;
            4'hB: r = OP_ADD;
            4'hC: r = OP_JMP;
            4'hD: r = OP_JSR;
            4'hE: r = OP_LDX;
            default: r = OP_STX;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/opdec_base_map.sv
module opdec_base_map
    import opdec_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ESC_CODE = 8'h9E
) (
    input  logic [BYTE_W-1:0] byte_i,
    output dec_t              dec_o,
    output logic              esc_o
);

    logic [NIB_W-1:0] hi_w;
    logic [NIB_W-1:0] lo_w;
    op_e              op_w;
    grp_e             grp_w;

    assign hi_w  = byte_i[BYTE_W-1:NIB_W];
    assign lo_w  = byte_i[NIB_W-1:0];
    assign esc_o = (byte_i == ESC_CODE);

    always_comb begin
        op_w  = OP_INV;
        grp_w = GRP_NONE;
        case (hi_w)
            4'h0: begin op_w = OP_BRBIT;   grp_w = GRP_BITBR;  end
            4'h1: begin op_w = OP_BSETCLR; grp_w = GRP_BITSC;  end
            4'h2: begin op_w = OP_BRCOND;  grp_w = GRP_BRANCH; end
            4'h3, 4'h4, 4'h5, 4'h6, 4'h7: begin
                grp_w = GRP_RMW;
                case (lo_w)
                    4'h2: begin
                        case (hi_w)
                            4'h3:    op_w = OP_LDHX;
                            4'h4:    op_w = OP_MUL;
                            4'h5:    op_w = OP_DIV;
                            4'h6:    op_w = OP_NSA;
                            default: op_w = OP_DAA;
                        endcase
                    end
                    4'h5: begin
                        case (hi_w)
                            4'h3:       op_w = OP_STHX;
                            4'h4, 4'h5: op_w = OP_LDHX;
                            default:    op_w = OP_CPHX;
                        endcase
                    end
                    4'hE:    op_w = (hi_w == 4'h3) ? OP_CPHX : OP_MOV;
                    default: op_w = rmw_slot(lo_w);
                endcase
            end
            4'h8: begin
                grp_w = GRP_CTRL;
                case (lo_w)
                    4'h0:                      op_w = OP_RTI;
                    4'h1:                      op_w = OP_RTS;
                    4'h3:                      op_w = OP_SWI;
                    4'h4, 4'h5:                op_w = OP_XFER;
                    4'h6, 4'h7, 4'h8, 4'h9,
                    4'hA, 4'hB:                op_w = OP_PSHPUL;
                    4'hC:                      op_w = OP_CLRH;
                    4'hE:                      op_w = OP_STOP;
                    4'hF:                      op_w = OP_WAIT;
                    default:                   op_w = OP_INV;
                endcase
            end
            4'h9: begin
                grp_w = GRP_MISC;
                case (lo_w)
                    4'h0, 4'h1, 4'h2, 4'h3:    op_w = OP_BRCOND;
                    4'h4, 4'h5, 4'h7, 4'hF:    op_w = OP_XFER;
                    4'h6:                      op_w = OP_STHX;
                    4'h8, 4'h9, 4'hA, 4'hB:    op_w = OP_FLAGOP;
                    4'hC:                      op_w = OP_RSP;
                    4'hD:                      op_w = OP_NOP;
                    default:                   op_w = OP_INV;
                endcase
            end
            default: begin
                grp_w = GRP_ALU;
                op_w  = alu_slot(lo_w);
                if (hi_w == 4'hA) begin
                    case (lo_w)
                        4'h7:    op_w = OP_AIS;
                        4'hC:    op_w = OP_INV;
                        4'hD:    op_w = OP_BSR;
                        4'hF:    op_w = OP_AIX;
                        default: op_w = alu_slot(lo_w);
                    endcase
                end
            end
        endcase
        dec_o.op  = op_w;
        dec_o.inv = (op_w == OP_INV);
        dec_o.grp = (op_w == OP_INV) ? GRP_NONE : grp_w;
    end

    // R11
    always_comb begin
        if (dec_o.inv && !$isunknown(byte_i)) begin
            base_inv_chk: assert (byte_i == 8'h82 || byte_i == 8'h8D ||
                                  byte_i == 8'hAC || byte_i == ESC_CODE)
                else $error("one-byte map flagged 0x%02h invalid", byte_i);
        end
    end

endmodule

// File: rtl/opdec_esc_map.sv
module opdec_esc_map
    import opdec_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output dec_t              dec_o
);

    logic [NIB_W-1:0] hi_w;
    logic [NIB_W-1:0] lo_w;
    op_e              op_w;
    grp_e             grp_w;

    assign hi_w = byte_i[BYTE_W-1:NIB_W];
    assign lo_w = byte_i[NIB_W-1:0];

    always_comb begin
        op_w  = OP_INV;
        grp_w = GRP_NONE;
        case (hi_w)
            4'h6: begin
                grp_w = GRP_RMW;
                op_w  = rmw_slot(lo_w);
            end
            4'hD, 4'hE: begin
                grp_w = GRP_ALU;
                op_w  = (lo_w == 4'hC || lo_w == 4'hD) ? OP_INV : alu_slot(lo_w);
            end
            4'hA, 4'hB, 4'hC: begin
                grp_w = GRP_ALU;
                op_w  = (lo_w == 4'hE) ? OP_LDHX : OP_INV;
            end
            4'hF: begin
                grp_w = GRP_ALU;
                case (lo_w)
                    4'h3:    op_w = OP_CPHX;
                    4'hE:    op_w = OP_LDHX;
                    4'hF:    op_w = OP_STHX;
                    default: op_w = OP_INV;
                endcase
            end
            default: op_w = OP_INV;
        endcase
        dec_o.op  = op_w;
        dec_o.inv = (op_w == OP_INV);
        dec_o.grp = (op_w == OP_INV) ? GRP_NONE : grp_w;
    end

endmodule

// File: rtl/opdec_top.sv
module opdec_top
    import opdec_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFE,
    parameter logic [BYTE_W-1:0] ESC_CODE = 8'h9E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              vec_load,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              res_valid,
    output logic [OP_W-1:0]   res_op,
    output logic [GRP_W-1:0]  res_grp,
    output logic              res_stack,
    output logic              res_inv,
    output logic [CNT_W-1:0]  res_bytes
);

    localparam logic [CNT_W-1:0] ONE_BYTE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO_BYTE = CNT_W'(2);

    seq_t st_d;
    seq_t st_q;
    dec_t base_dec;
    dec_t esc_dec;
    logic base_esc;
    logic take;

    opdec_base_map #(.ESC_CODE(ESC_CODE)) u_base (
        .byte_i (in_byte),
        .dec_o  (base_dec),
        .esc_o  (base_esc)
    );

    opdec_esc_map u_esc (
        .byte_i (in_byte),
        .dec_o  (esc_dec)
    );

    assign take = in_valid && !st_q.vec;

    always_comb begin
        st_d        = st_q;
        st_d.vec    = 1'b0;
        st_d.rvalid = 1'b0;
        if (take) begin
            if (!st_q.pend && base_esc) begin
                st_d.pend = 1'b1;
            end else begin
                st_d.rvalid = 1'b1;
                st_d.pend   = 1'b0;
                st_d.dec    = st_q.pend ? esc_dec : base_dec;
                st_d.stack  = st_q.pend && !esc_dec.inv;
                st_d.nbytes = st_q.pend ? TWO_BYTE : ONE_BYTE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vec     <= 1'b1;
            st_q.pend    <= 1'b0;
            st_q.rvalid  <= 1'b0;
            st_q.stack   <= 1'b0;
            st_q.nbytes  <= '0;
            st_q.dec.op  <= OP_INV;
            st_q.dec.grp <= GRP_NONE;
            st_q.dec.inv <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = !st_q.vec;
    assign vec_load  = st_q.vec;
    assign vec_addr  = VEC_ADDR;
    assign res_valid = st_q.rvalid;
    assign res_op    = st_q.dec.op;
    assign res_grp   = st_q.dec.grp;
    assign res_stack = st_q.stack;
    assign res_inv   = st_q.dec.inv;
    assign res_bytes = st_q.nbytes;

    // R1
    vec_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |=> (!vec_load && in_ready));

    // R2
    res_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid && in_ready));

    // R3
    esc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_byte == ESC_CODE && !st_q.pend)
            |=> (!res_valid && st_q.pend));

    // R13
    two_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && st_q.pend)
            |=> (res_valid && res_bytes == TWO_BYTE && !st_q.pend));

    // R9
    stack_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_stack) |-> (res_bytes == TWO_BYTE && !res_inv));

endmodule

// File: tb/tb_opdec_top.sv
module tb_opdec_top;
    import opdec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        vec_load;
    logic [15:0] vec_addr;
    logic        res_valid;
    logic [5:0]  res_op;
    logic [2:0]  res_grp;
    logic        res_stack;
    logic        res_inv;
    logic [1:0]  res_bytes;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    // behavioural reference state
    bit       m_vec = 1'b1;
    bit       m_pend = 1'b0;
    bit       m_valid = 1'b0;
    bit       m_esc = 1'b0;
    bit [7:0] m_byte = 8'h00;

    op_e rmw_t[16];
    op_e alu_t[16];

    always #10 clk = ~clk;

    opdec_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .vec_load(vec_load), .vec_addr(vec_addr),
        .res_valid(res_valid), .res_op(res_op), .res_grp(res_grp),
        .res_stack(res_stack), .res_inv(res_inv), .res_bytes(res_bytes)
    );

    initial begin
        rmw_t = '{OP_NEG, OP_CBEQ, OP_INV, OP_COM, OP_LSR, OP_INV, OP_ROR, OP_ASR,
                  OP_LSL, OP_ROL, OP_DEC, OP_DBNZ, OP_INC, OP_TST, OP_INV, OP_CLR};
        alu_t = '{OP_SUB, OP_CMP, OP_SBC, OP_CPX, OP_AND, OP_BIT, OP_LDA, OP_STA,
                  OP_EOR, OP_ADC, OP_ORA, OP_ADD, OP_JMP, OP_JSR, OP_LDX, OP_STX};
    end

    function automatic void ref_dec(input bit esc, input bit [7:0] b,
                                    output op_e op, output grp_e g);
        int hi = int'(b[7:4]);
        int lo = int'(b[3:0]);
        op = OP_INV;
        g  = GRP_NONE;
        if (!esc) begin
            if (hi == 0)      begin op = OP_BRBIT;   g = GRP_BITBR;  end
            else if (hi == 1) begin op = OP_BSETCLR; g = GRP_BITSC;  end
            else if (hi == 2) begin op = OP_BRCOND;  g = GRP_BRANCH; end
            else if (hi <= 7) begin
                g = GRP_RMW;
                if (b == 8'h32 || b == 8'h45 || b == 8'h55) op = OP_LDHX;
                else if (b == 8'h42) op = OP_MUL;
                else if (b == 8'h52) op = OP_DIV;
                else if (b == 8'h62) op = OP_NSA;
                else if (b == 8'h72) op = OP_DAA;
                else if (b == 8'h35) op = OP_STHX;
                else if (b == 8'h65 || b == 8'h75 || b == 8'h3E) op = OP_CPHX;
                else if (lo == 14) op = OP_MOV;
                else op = rmw_t[lo];
            end else if (hi == 8) begin
                g = GRP_CTRL;
                if (lo == 0) op = OP_RTI;
                else if (lo == 1) op = OP_RTS;
                else if (lo == 3) op = OP_SWI;
                else if (lo == 4 || lo == 5) op = OP_XFER;
                else if (lo >= 6 && lo <= 11) op = OP_PSHPUL;
                else if (lo == 12) op = OP_CLRH;
                else if (lo == 14) op = OP_STOP;
                else if (lo == 15) op = OP_WAIT;
            end else if (hi == 9) begin
                g = GRP_MISC;
                if (lo <= 3) op = OP_BRCOND;
                else if (lo == 4 || lo == 5 || lo == 7 || lo == 15) op = OP_XFER;
                else if (lo == 6) op = OP_STHX;
                else if (lo <= 11) op = OP_FLAGOP;
                else if (lo == 12) op = OP_RSP;
                else if (lo == 13) op = OP_NOP;
            end else begin
                g  = GRP_ALU;
                op = alu_t[lo];
                if (b == 8'hA7) op = OP_AIS;
                if (b == 8'hAD) op = OP_BSR;
                if (b == 8'hAF) op = OP_AIX;
                if (b == 8'hAC) op = OP_INV;
            end
        end else begin
            if (hi == 6) begin g = GRP_RMW; op = rmw_t[lo]; end
            else if ((hi == 13 || hi == 14) && lo != 12 && lo != 13) begin
                g = GRP_ALU; op = alu_t[lo];
            end else if (b == 8'hAE || b == 8'hBE || b == 8'hCE || b == 8'hFE) begin
                g = GRP_ALU; op = OP_LDHX;
            end else if (b == 8'hF3) begin g = GRP_ALU; op = OP_CPHX; end
            else if (b == 8'hFF) begin g = GRP_ALU; op = OP_STHX; end
        end
        if (op == OP_INV) g = GRP_NONE;
    endfunction

    function automatic string op_tag(input bit esc, input bit [7:0] b, input bit inv);
        int hi = int'(b[7:4]);
        int lo = int'(b[3:0]);
        if (esc) return inv ? "R10" : "R9";
        if (inv) return "R11";
        if (hi <= 2) return "R4";
        if (hi <= 7) return (lo == 2 || lo == 5 || lo == 14) ? "R6" : "R5";
        if (hi <= 9) return "R8";
        return "R7";
    endfunction

    // reference model, one step per clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_vec   <= 1'b1;
            m_pend  <= 1'b0;
            m_valid <= 1'b0;
        end else begin
            m_valid <= 1'b0;
            if (m_vec) begin
                m_vec <= 1'b0;
            end else if (in_valid) begin
                if (!m_pend && in_byte == 8'h9E) begin
                    m_pend <= 1'b1;
                end else begin
                    m_valid <= 1'b1;
                    m_esc   <= m_pend;
                    m_byte  <= in_byte;
                    m_pend  <= 1'b0;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!done) begin
            op_e  e_op;
            grp_e e_grp;
            vectors++;
            chk("R1", "vec_load", int'(vec_load), int'(m_vec));
            chk("R1", "vec_addr", int'(vec_addr), 16'hFFFE);
            chk("R2", "in_ready", int'(in_ready), int'(!m_vec));
            // R3: no result while the prefix alone has been taken
            chk("R2", "res_valid", int'(res_valid), int'(m_valid));
            if (m_valid) begin
                ref_dec(m_esc, m_byte, e_op, e_grp);
                chk(op_tag(m_esc, m_byte, e_op == OP_INV), "res_op", int'(res_op), int'(e_op));
                chk(m_esc ? "R9" : "R4", "res_grp", int'(res_grp), int'(e_grp));
                chk(m_esc ? "R10" : "R11", "res_inv", int'(res_inv), int'(e_op == OP_INV));
                chk(m_esc ? "R9" : "R11", "res_stack", int'(res_stack),
                    int'(m_esc && e_op != OP_INV));
                // R12 is seen here too: a cleared prefix gives one byte
                chk("R13", "res_bytes", int'(res_bytes), m_esc ? 2 : 1);
            end
        end
    end

    task automatic put(input logic [7:0] b);
        bit r;
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        forever begin
            r = in_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R2 watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: a byte offered during the vector cycle waits until it ends
        rst_n    = 1'b1;
        in_valid = 1'b1;
        in_byte  = 8'h9D;
        @(posedge clk);
        @(posedge clk);
        // one-byte map sweep: R4 R5 R6 R7 R8 R11
        for (int b = 0; b < 256; b++) begin
            if (b != 8'h9E) put(8'(b));
            if (b % 7 == 3) idle(2);
        end
        idle(1);
        // escape map sweep: R3 R9 R10
        for (int s = 0; s < 256; s++) begin
            put(8'h9E);
            if (s % 5 == 0) idle(1);
            put(8'(s));
            if (s % 11 == 0) idle(1);
        end
        // doubled prefix, then back-to-back mix
        put(8'h9E); put(8'h9E);
        put(8'h9E); put(8'hE6); put(8'h9E); put(8'h6C); put(8'hAB); put(8'h4E);
        idle(2);
        // R12: reset lands between prefix and second byte
        put(8'h9E);
        pulse_reset();
        put(8'h40);
        put(8'h9E); put(8'hDC);
        idle(3);
        finish_run();
    end

endmodule